// File: doc/BRIEF.md
# Graphics Command Queue Control Registers

This block is the 16-bit register file that sits beside the engine draining a graphics command queue held in memory. Software reaches it over a simple halfword bus. It holds a status word, a control word, a token word and eight 32-bit queue pointers. The pointers are the base, the end, the write position, the read position, a high mark, a low mark, a read/write distance and a break address. Each pointer is reached as two separate halfwords. The control bits are also driven out to the queue engine.

The engine owns the status flags. When it presents an update strobe, the block loads its status word. Software can overwrite the status word, clear the watermark flags through a clear register, and drop a pending break flag by turning off both break controls. Three status flags, each gated by its own enable bit in the control word, are ORed into one interrupt line. Every write to the status, control or clear register takes effect on the next clock edge. The interrupt follows at that same edge. Reads are combinational.

Addresses are byte addresses. The register index is byte address bits [11:1], and bits above 11 are ignored. Index 0 is the status register, index 1 the control register, index 2 the clear register and index 7 the token register. Pointer k has its low half at index 16+2k and its high half at index 17+2k. The values of k are: 0 base, 1 end, 2 write position, 3 read position, 4 high mark, 5 low mark, 6 distance, 7 break address.

Top module: `cfr_top`

## Requirements
- R1: After reset the status word reads 0x000C, with the read-idle bit 2 and the command-idle bit 3 set and all other bits clear. The control word, the token and every pointer half read 0, and `irq` is 0.
- R2: A write to a pointer's low-half index replaces bits [15:0] of that pointer and leaves bits [31:16] unchanged. A write to its high-half index replaces bits [31:16] and leaves bits [15:0] unchanged.
- R3: The read index is `bus_addr[11:1]`, and address bits above 11 play no part. Indices 32 and up read 0. So do the clear register and every unassigned index below 32, and writes to all of them change nothing.
- R4: A control write whose bit 1 (break enable) and bit 5 (break interrupt enable) are both 0 clears status bit 4 (break hit). A control write with either of those bits set leaves status bit 4 as it was.
- R5: A clear-register write with bit 0 set clears status bit 0 (overflow). A clear-register write with bit 1 set clears status bit 1 (underflow). The other status bits are left unchanged.
- R6: `irq` is the OR of three terms: status bit 4 AND control bit 5, status bit 0 AND control bit 2, and status bit 1 AND control bit 3. It changes in the cycle after the write or engine update that changes those bits.
- R7: While `bus_wide` is high, `bus_rdata` is 0 and a write changes no register.
- R8: When `eng_upd` is high, the status word takes the value `eng_status`. A bus write to the status, control or clear register in the same cycle is applied after the engine update, so the bus write wins.
- R9: A status write stores `bus_wdata[4:0]`, and a token write stores all 16 bits. Both read back zero-extended.
- R10: `ctrl_out` always equals the stored control word, laid out as bit 0 read enable, bit 1 break enable, bit 2 overflow interrupt enable, bit 3 underflow interrupt enable, bit 4 link enable and bit 5 break interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wide | input | 1 | Marks a 32-bit access, which is not supported |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| eng_upd | input | 1 | Engine status update strobe |
| eng_status | input | 5 | New status word from the engine |
| ctrl_out | output | 6 | Stored control word |
| irq | output | 1 | Interrupt request |

## Verification
The engine's status update and a software write to the status, control or clear register can fall in the same clock cycle. The bench drives such pairs on purpose: an engine update that raises overflow and break while software clears overflow, and one that raises break while software writes a control word with both break bits off. It then judges the next-cycle status readback and `irq` against a reference model that applies the engine first and the bus second. A randomised phase mixes engine strobes and bus writes freely and compares every cycle.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int HALF_W    = 16;
    localparam int PTR_W     = 2 * HALF_W;
    localparam int NUM_PTR   = 8;
    localparam int IDX_W     = 11;
    localparam int IDX_LIMIT = 32;
    localparam int STAT_W    = 5;
    localparam int CTRL_W    = 6;

    localparam int IDX_STATUS   = 0;
    localparam int IDX_CTRL     = 1;
    localparam int IDX_CLEAR    = 2;
    localparam int IDX_TOKEN    = 7;
    localparam int IDX_PTR_BASE = 16;

    // status bit positions
    localparam int ST_OVF   = 0;
    localparam int ST_UDF   = 1;
    localparam int ST_RIDLE = 2;
    localparam int ST_CIDLE = 3;
    localparam int ST_BRK   = 4;

    // control bit positions
    localparam int CT_RD_EN   = 0;
    localparam int CT_BRK_EN  = 1;
    localparam int CT_OVF_IE  = 2;
    localparam int CT_UDF_IE  = 3;
    localparam int CT_LINK_EN = 4;
    localparam int CT_BRK_IE  = 5;

    // clear register bit positions
    localparam int CLR_OVF = 0;
    localparam int CLR_UDF = 1;

    localparam logic [STAT_W-1:0] STATUS_RST =
        STAT_W'((1 << ST_RIDLE) | (1 << ST_CIDLE));

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [CTRL_W-1:0] ctrl;
        logic [HALF_W-1:0] token;
    } core_regs_t;

    typedef struct packed {
        logic               st;
        logic               ct;
        logic               clr;
        logic               tok;
        logic [NUM_PTR-1:0] ptr_lo;
        logic [NUM_PTR-1:0] ptr_hi;
    } wr_sel_t;
endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
    import cfr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              idx_in_range,
    output wr_sel_t           wsel
);
    logic unused_addr_bits;
    logic wr_ok;

    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:IDX_W+1], bus_addr[0]};
    assign reg_idx      = bus_addr[IDX_W:1];
    assign idx_in_range = (reg_idx < IDX_W'(IDX_LIMIT));
    assign wr_ok        = bus_wr && !bus_wide && idx_in_range;

    always_comb begin
        wsel     = '0;
        wsel.st  = wr_ok && (reg_idx == IDX_W'(IDX_STATUS));
        wsel.ct  = wr_ok && (reg_idx == IDX_W'(IDX_CTRL));
        wsel.clr = wr_ok && (reg_idx == IDX_W'(IDX_CLEAR));
        wsel.tok = wr_ok && (reg_idx == IDX_W'(IDX_TOKEN));
        for (int k = 0; k < NUM_PTR; k++) begin
            wsel.ptr_lo[k] = wr_ok && (reg_idx == IDX_W'(IDX_PTR_BASE + 2 * k));
            wsel.ptr_hi[k] = wr_ok && (reg_idx == IDX_W'(IDX_PTR_BASE + 2 * k + 1));
        end
    end
endmodule

// File: rtl/cfr_ptr_bank.sv
module cfr_ptr_bank
    import cfr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [HALF_W-1:0]               wdata,
    input  logic [NUM_PTR-1:0]              we_lo,
    input  logic [NUM_PTR-1:0]              we_hi,
    output logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_q
);
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic [PTR_W-1:0] ent_d;
        logic [PTR_W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we_lo[g]) ent_d[HALF_W-1:0]     = wdata;
            if (we_hi[g]) ent_d[PTR_W-1:HALF_W] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ptr_q[g] = ent_q;
    end
endmodule

// File: rtl/cfr_core_regs.sv
module cfr_core_regs
    import cfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           wsel,
    input  logic [HALF_W-1:0] wdata,
    input  logic              eng_upd,
    input  logic [STAT_W-1:0] eng_status,
    output core_regs_t        regs_q,
    output logic              irq
);
    core_regs_t regs_d;
    core_regs_t regs_r;

    always_comb begin
        regs_d = regs_r;
        // engine first, software second: the bus write wins
        if (eng_upd) regs_d.status = eng_status;
        if (wsel.st) regs_d.status = wdata[STAT_W-1:0];
        if (wsel.ct) begin
            regs_d.ctrl = wdata[CTRL_W-1:0];
            if (!wdata[CT_BRK_EN] && !wdata[CT_BRK_IE])
                regs_d.status[ST_BRK] = 1'b0;
        end
        if (wsel.clr) begin
            if (wdata[CLR_OVF]) regs_d.status[ST_OVF] = 1'b0;
            if (wdata[CLR_UDF]) regs_d.status[ST_UDF] = 1'b0;
        end
        if (wsel.tok) regs_d.token = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_r.status <= STATUS_RST;
            regs_r.ctrl   <= '0;
            regs_r.token  <= '0;
        end else begin
            regs_r <= regs_d;
        end
    end

    assign regs_q = regs_r;
    assign irq = (regs_r.status[ST_BRK] && regs_r.ctrl[CT_BRK_IE])
              || (regs_r.status[ST_OVF] && regs_r.ctrl[CT_OVF_IE])
              || (regs_r.status[ST_UDF] && regs_r.ctrl[CT_UDF_IE]);
endmodule

// File: rtl/cfr_top.sv
module cfr_top
    import cfr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              eng_upd,
    input  logic [4:0]        eng_status,
    output logic [5:0]        ctrl_out,
    output logic              irq
);
    logic [IDX_W-1:0]                reg_idx;
    logic                            idx_in_range;
    wr_sel_t                         wsel;
    core_regs_t                      core_q;
    logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_q;
    logic [STAT_W-1:0]               status_view;

    cfr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr       (bus_wr),
        .bus_wide     (bus_wide),
        .bus_addr     (bus_addr),
        .reg_idx      (reg_idx),
        .idx_in_range (idx_in_range),
        .wsel         (wsel)
    );

    cfr_core_regs u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wsel       (wsel),
        .wdata      (bus_wdata),
        .eng_upd    (eng_upd),
        .eng_status (eng_status),
        .regs_q     (core_q),
        .irq        (irq)
    );

    cfr_ptr_bank u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wdata (bus_wdata),
        .we_lo (wsel.ptr_lo),
        .we_hi (wsel.ptr_hi),
        .ptr_q (ptr_q)
    );

    assign status_view = core_q.status;
    assign ctrl_out    = core_q.ctrl;

    always_comb begin
        bus_rdata = '0;
        if (!bus_wide && idx_in_range) begin
            if (reg_idx == IDX_W'(IDX_STATUS))
                bus_rdata = HALF_W'(core_q.status);
            else if (reg_idx == IDX_W'(IDX_CTRL))
                bus_rdata = HALF_W'(core_q.ctrl);
            else if (reg_idx == IDX_W'(IDX_TOKEN))
                bus_rdata = core_q.token;
            else begin
                for (int k = 0; k < NUM_PTR; k++) begin
                    if (reg_idx == IDX_W'(IDX_PTR_BASE + 2 * k))
                        bus_rdata = ptr_q[k][HALF_W-1:0];
                    if (reg_idx == IDX_W'(IDX_PTR_BASE + 2 * k + 1))
                        bus_rdata = ptr_q[k][PTR_W-1:HALF_W];
                end
            end
        end
    end
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [4:0]        status_q,
    input logic [5:0]        ctrl_q,
    input logic              irq
);
    logic [10:0] idx;
    logic        unused_chk_bits;
    logic        wr_narrow;

    assign idx             = bus_addr[11:1];
    assign unused_chk_bits = ^{bus_addr[ADDR_W-1:12], bus_addr[0], bus_wdata[15:6]};
    assign wr_narrow       = bus_wr && !bus_wide;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status_q == 5'h0C && ctrl_q == 6'h0 && !irq)); // R1

    AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx >= 11'd32) |-> (bus_rdata == 16'h0)); // R3

    AST_BRK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_narrow && idx == 11'd1 && !bus_wdata[1] && !bus_wdata[5]) |=> !status_q[4]); // R4

    AST_CLR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_narrow && idx == 11'd2 && bus_wdata[0]) |=> !status_q[0]); // R5

    AST_CLR_UDF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_narrow && idx == 11'd2 && bus_wdata[1]) |=> !status_q[1]); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[2] && !ctrl_q[3] && !ctrl_q[5]) |-> !irq); // R6

    AST_WIDE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wide |-> (bus_rdata == 16'h0)); // R7

    AST_WIDE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wide) |=> (ctrl_q == $past(ctrl_q))); // R7
endmodule

bind cfr_top cfr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status_q  (status_view),
    .ctrl_q    (ctrl_out),
    .irq       (irq)
);

// File: tb/cfr_top_tb_top.sv
module cfr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        eng_upd = 1'b0;
    logic [4:0]  eng_status = '0;
    logic [5:0]  ctrl_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [4:0]  m_st;
    logic [5:0]  m_ct;
    logic [15:0] m_tok;
    logic [31:0] m_ptr [8];

    always #4 clk = ~clk;

    cfr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_upd(eng_upd), .eng_status(eng_status), .ctrl_out(ctrl_out), .irq(irq)
    );

    function automatic logic [15:0] m_read(input logic [15:0] a, input logic w);
        int i;
        i = int'(a[11:1]);
        if (w) return 16'h0;
        if (i == 0) return {11'h0, m_st};
        if (i == 1) return {10'h0, m_ct};
        if (i == 7) return m_tok;
        if (i >= 16 && i < 32) begin
            if (i % 2 == 0) return m_ptr[(i - 16) / 2][15:0];
            else            return m_ptr[(i - 16) / 2][31:16];
        end
        return 16'h0;
    endfunction

    function automatic logic m_irq();
        return (m_st[4] & m_ct[5]) | (m_st[0] & m_ct[2]) | (m_st[1] & m_ct[3]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 5'h0C; m_ct = '0; m_tok = '0;
            foreach (m_ptr[p]) m_ptr[p] = '0;
        end else begin
            int i;
            i = int'(bus_addr[11:1]);
            if (eng_upd) m_st = eng_status;
            if (bus_wr && !bus_wide) begin
                if (i == 0) m_st = bus_wdata[4:0];
                else if (i == 1) begin
                    m_ct = bus_wdata[5:0];
                    if (!bus_wdata[1] && !bus_wdata[5]) m_st[4] = 1'b0;
                end else if (i == 2) begin
                    if (bus_wdata[0]) m_st[0] = 1'b0;
                    if (bus_wdata[1]) m_st[1] = 1'b0;
                end else if (i == 7) m_tok = bus_wdata;
                else if (i >= 16 && i < 32) begin
                    if (i % 2 == 0) m_ptr[(i - 16) / 2][15:0]  = bus_wdata;
                    else            m_ptr[(i - 16) / 2][31:16] = bus_wdata;
                end
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, then compare every output against the model
    task automatic step(input string req, input logic wr, input logic wide,
                        input logic [15:0] a, input logic [15:0] d,
                        input logic upd, input logic [4:0] es);
        @(negedge clk);
        bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = d;
        eng_upd = upd; eng_status = es;
        #1;
        check(req, bus_rdata, m_read(a, wide));
        check("R6", {15'h0, irq}, {15'h0, m_irq()});
        check("R10", {10'h0, ctrl_out}, {10'h0, m_ct});
    endtask

    task automatic rd(input string req, input logic [15:0] a);
        step(req, 1'b0, 1'b0, a, 16'h0, 1'b0, 5'h0);
    endtask

    task automatic wr(input string req, input logic [15:0] a, input logic [15:0] d);
        step(req, 1'b1, 1'b0, a, d, 1'b0, 5'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, with fixed expectations as well
        rd("R1", 16'h0000);
        check("R1", bus_rdata, 16'h000C);
        rd("R1", 16'h0002);
        check("R1", bus_rdata, 16'h0000);
        rd("R1", 16'h000E);
        rd("R1", 16'h0020);
        rd("R1", 16'h003E);

        // R2 half writes
        wr("R2", 16'h0021, 16'hBEEF);
        wr("R2", 16'h0022, 16'h1234);
        rd("R2", 16'h0020);
        check("R2", bus_rdata, 16'hBEEF);
        rd("R2", 16'h0022);
        wr("R2", 16'h003E, 16'hA5A5);
        wr("R2", 16'h003C, 16'h5A5A);
        wr("R2", 16'h003E, 16'h0F0F);
        rd("R2", 16'h003C);
        check("R2", bus_rdata, 16'h5A5A);
        rd("R2", 16'h003E);
        check("R2", bus_rdata, 16'h0F0F);

        // R3 aliasing, reserved and out-of-range indices
        rd("R3", 16'hF020);
        check("R3", bus_rdata, 16'hBEEF);
        wr("R3", 16'h0006, 16'hFFFF);
        wr("R3", 16'h0040, 16'hFFFF);
        wr("R3", 16'h0FFE, 16'hFFFF);
        for (int a = 4; a < 16'h20; a += 2) if (a != 16'h0E) rd("R3", 16'(a));
        rd("R3", 16'h0040);
        rd("R3", 16'h0004);
        rd("R3", 16'h0000);

        // R9 token and status writes
        wr("R9", 16'h000E, 16'hC0DE);
        rd("R9", 16'h000E);
        check("R9", bus_rdata, 16'hC0DE);
        wr("R9", 16'h0000, 16'hFFE3);
        rd("R9", 16'h0000);
        check("R9", bus_rdata, 16'h0003);

        // R6 and R5: enables then clears
        wr("R6", 16'h0002, 16'h000C);
        rd("R6", 16'h0000);
        check("R6", {15'h0, irq}, 16'h1);
        wr("R5", 16'h0004, 16'h0001);
        rd("R5", 16'h0000);
        check("R5", bus_rdata, 16'h0002);
        wr("R5", 16'h0004, 16'h0002);
        rd("R5", 16'h0000);
        check("R5", bus_rdata, 16'h0000);
        check("R6", {15'h0, irq}, 16'h0);

        // R4 break drop rule
        step("R8", 1'b0, 1'b0, 16'h0000, 16'h0, 1'b1, 5'h10);
        wr("R4", 16'h0002, 16'h0022);
        rd("R4", 16'h0000);
        check("R4", bus_rdata, 16'h0010);
        check("R6", {15'h0, irq}, 16'h1);
        wr("R4", 16'h0002, 16'h0002);
        rd("R4", 16'h0000);
        check("R4", bus_rdata, 16'h0010);
        wr("R4", 16'h0002, 16'h001D);
        rd("R4", 16'h0000);
        check("R4", bus_rdata, 16'h0000);

        // R8 same-cycle collisions
        step("R8", 1'b1, 1'b0, 16'h0004, 16'h0001, 1'b1, 5'h11);
        rd("R8", 16'h0000);
        check("R8", bus_rdata, 16'h0010);
        step("R8", 1'b1, 1'b0, 16'h0002, 16'h0004, 1'b1, 5'h1F);
        rd("R8", 16'h0000);
        check("R8", bus_rdata, 16'h000F);
        step("R8", 1'b1, 1'b0, 16'h0000, 16'h0008, 1'b1, 5'h17);
        rd("R8", 16'h0000);
        check("R8", bus_rdata, 16'h0008);

        // R7 wide accesses
        step("R7", 1'b1, 1'b1, 16'h0002, 16'h003F, 1'b0, 5'h0);
        check("R7", bus_rdata, 16'h0000);
        step("R7", 1'b1, 1'b1, 16'h000E, 16'h1111, 1'b0, 5'h0);
        step("R7", 1'b0, 1'b1, 16'h000E, 16'h0, 1'b0, 5'h0);
        rd("R7", 16'h000E);
        check("R7", bus_rdata, 16'hC0DE);
        rd("R7", 16'h0002);
        check("R7", bus_rdata, 16'h0004);

        // randomised mix compared every cycle
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            a = 16'($urandom_range(0, 35)) << 1;
            if (($urandom & 7) == 0) a = a | 16'h0F00;
            step("R8", 1'($urandom), ($urandom % 10) == 0, a, 16'($urandom),
                 ($urandom % 4) == 0, 5'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule